// File: doc/BRIEF.md
# Channel Power-Saving Controller

This block gates power for one transmit/receive channel pair. It watches the transmit enable, the receive enable and one shared power-down pin. From these it decides how deeply each path is powered down. Each path has three gating outputs: datapath, PLL and LDO. A depth code selects how many of them are gated. The enable pins use one depth setting and the shared pin uses another. For each path, the deeper of the two requests wins.

Mode settings are written through a simple write strobe and are staged. A staged pair only takes effect at the next power-down event, so a setting never changes depth in the middle of a power-down interval. Power-down moves one depth level per clock. A power-up request drops straight to the new target from whatever level has been reached, and then starts a recovery count whose length depends on that level. A per-path ready output shows that the path is fully up and has recovered.

Two error flags are kept, and both stay set until reset. One marks a shared-pin raise while either enable is high; that raise is ignored. The other marks a mode pair that breaks the depth ordering rule or uses an undefined code.

Top module: `chan_pwr_ctrl`

## Requirements
- R1: A synchronous active-low reset clears every gating output and both error flags, drives both ready outputs high, and sets both applied and staged modes to 0.
- R2: After a falling edge on a path's enable with applied enable mode 1, the path's datapath gate asserts. Its LDO stays ungated. The other path's datapath is unaffected.
- R3: Depth codes are 0 = nothing gated, 1 = datapath and PLL gated, 2 = datapath, PLL and LDO gated. Power-down advances one code per clock, so a path's LDO gate is never seen without that path's PLL gate having been asserted on the previous clock.
- R4: With enable mode 0, enable edges leave all gating outputs low and both ready outputs high.
- R5: A shared-pin rising edge, seen while both enables are low, brings both paths to at least the pin mode depth. The pin's falling edge removes that request. Each path then returns to the depth its own enable still requests.
- R6: A shared-pin rising edge seen while either enable is high sets the pin error flag. It changes no gating output. The flag stays set until reset.
- R7: A write sets the config error flag when either code is 3, or when the pin code is nonzero and not greater than the enable code. The flag stays set until reset. A code of 3 is applied as 2.
- R8: A written mode pair is staged and only applies at the next power-down event: an enable falling edge or an accepted shared-pin rising edge. A write in the same clock as such an event stays staged for the event after it.
- R9: A path's ready output is low while it has a nonzero target or level. After power-up it stays low for REC1_CYC clocks when leaving depth 1 and REC2_CYC clocks when leaving depth 2. It rises on the clock after the count ends.
- R10: A power-up request during a power-down sequence stops it. Recovery starts from the depth reached, using that depth's count.
- R11: With SHARED_RES = 1, the PLL and LDO gates are common to both paths. Each is asserted only when both paths are at the depth that gates it, so both paths' PLL and LDO outputs are equal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tx_en | input | 1 | Transmit path enable, high means active |
| rx_en | input | 1 | Receive path enable, high means active |
| pd_pin | input | 1 | Shared power-down pin, high requests power-down of both paths |
| cfg_we | input | 1 | Write strobe for a new mode pair |
| cfg_en_mode | input | 2 | Depth code used on enable falling edges |
| cfg_pin_mode | input | 2 | Depth code used on shared-pin rising edges |
| tx_dp_pd | output | 1 | Transmit datapath gate |
| tx_pll_pd | output | 1 | Transmit PLL gate |
| tx_ldo_pd | output | 1 | Transmit LDO gate |
| rx_dp_pd | output | 1 | Receive datapath gate |
| rx_pll_pd | output | 1 | Receive PLL gate |
| rx_ldo_pd | output | 1 | Receive LDO gate |
| tx_rdy | output | 1 | Transmit path up and recovered |
| rx_rdy | output | 1 | Receive path up and recovered |
| pin_err | output | 1 | Sticky: shared pin raised while an enable was high |
| cfg_err | output | 1 | Sticky: illegal mode pair written |

## Verification
The bench targets a mode write that lands in the same clock as a power-down edge. A design that applies the write early gates the LDO at the wrong depth on that edge. It targets an enable bounce in the middle of a power-down. A design that does not abort, or that picks the count for the deeper level, holds ready low for the wrong number of clocks. It raises the shared pin with one path active and expects nothing to move. It lowers one path at a time with shared resources and expects the PLL to stay on until both paths have gone down. Recovery is checked on the exact clock ready returns, so a counter that is off by one shows up at once.

// File: rtl/pcs_pkg.sv
package pcs_pkg;
    typedef logic [1:0] depth_t;

    localparam depth_t DEPTH_NONE = 2'd0;
    localparam depth_t DEPTH_PLL  = 2'd1;
    localparam depth_t DEPTH_LDO  = 2'd2;

    function automatic depth_t sat_depth(input logic [1:0] code);
        return (code > DEPTH_LDO) ? DEPTH_LDO : depth_t'(code);
    endfunction

    function automatic depth_t max_depth(input depth_t a, input depth_t b);
        return (a > b) ? a : b;
    endfunction
endpackage

// File: rtl/pcs_cfg.sv
module pcs_cfg
    import pcs_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       we_i,
    input  logic [1:0] en_code_i,
    input  logic [1:0] pin_code_i,
    input  logic       pd_event_i,
    output depth_t     use_en_o,
    output depth_t     use_pin_o,
    output logic       err_o
);
    typedef struct packed {
        depth_t act_en;
        depth_t act_pin;
        depth_t stg_en;
        depth_t stg_pin;
        logic   stg_vld;
        logic   err;
    } cfg_st_t;

    cfg_st_t st_d, st_q;
    logic    bad_pair;

    assign use_en_o  = st_q.stg_vld ? st_q.stg_en  : st_q.act_en;
    assign use_pin_o = st_q.stg_vld ? st_q.stg_pin : st_q.act_pin;
    assign err_o     = st_q.err;

    always_comb begin
        bad_pair = (en_code_i == 2'd3) || (pin_code_i == 2'd3) ||
                   ((pin_code_i != 2'd0) &&
                    (sat_depth(pin_code_i) <= sat_depth(en_code_i)));
        st_d = st_q;
        if (pd_event_i) begin
            st_d.act_en  = use_en_o;
            st_d.act_pin = use_pin_o;
            st_d.stg_vld = 1'b0;
        end
        if (we_i) begin
            st_d.stg_en  = sat_depth(en_code_i);
            st_d.stg_pin = sat_depth(pin_code_i);
            st_d.stg_vld = 1'b1;
            st_d.err     = st_q.err | bad_pair;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/pcs_path.sv
module pcs_path
    import pcs_pkg::*;
#(
    parameter int REC1_CYC = 6,
    parameter int REC2_CYC = 14
) (
    input  logic   clk,
    input  logic   rst_n,
    input  depth_t tgt_i,
    output depth_t lvl_o,
    output logic   rdy_o
);
    localparam int CW = $clog2(REC2_CYC + 1);
    localparam logic [CW-1:0] LOAD1 = CW'(REC1_CYC);
    localparam logic [CW-1:0] LOAD2 = CW'(REC2_CYC);

    typedef struct packed {
        depth_t        lvl;
        logic [CW-1:0] cnt;
    } path_st_t;

    path_st_t st_d, st_q;

    assign lvl_o = st_q.lvl;
    assign rdy_o = (st_q.lvl == DEPTH_NONE) && (tgt_i == DEPTH_NONE) &&
                   (st_q.cnt == '0);

    always_comb begin
        st_d = st_q;
        if (tgt_i > st_q.lvl) begin
            st_d.lvl = st_q.lvl + depth_t'(1);
            st_d.cnt = '0;
        end else if (tgt_i < st_q.lvl) begin
            st_d.lvl = tgt_i;
            st_d.cnt = (st_q.lvl == DEPTH_LDO) ? LOAD2 : LOAD1;
        end else if (st_q.cnt != '0) begin
            st_d.cnt = st_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/chan_pwr_ctrl.sv
module chan_pwr_ctrl
    import pcs_pkg::*;
#(
    parameter int REC1_CYC   = 6,
    parameter int REC2_CYC   = 14,
    parameter bit SHARED_RES = 1'b1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tx_en,
    input  logic       rx_en,
    input  logic       pd_pin,
    input  logic       cfg_we,
    input  logic [1:0] cfg_en_mode,
    input  logic [1:0] cfg_pin_mode,
    output logic       tx_dp_pd,
    output logic       tx_pll_pd,
    output logic       tx_ldo_pd,
    output logic       rx_dp_pd,
    output logic       rx_pll_pd,
    output logic       rx_ldo_pd,
    output logic       tx_rdy,
    output logic       rx_rdy,
    output logic       pin_err,
    output logic       cfg_err
);
    localparam int NPATH = 2;

    typedef struct packed {
        logic [NPATH-1:0]   prev_en;
        logic               prev_pin;
        depth_t [NPATH-1:0] en_lvl;
        depth_t             pin_lvl;
        logic               pin_err;
    } top_st_t;

    top_st_t            st_d, st_q;
    logic [NPATH-1:0]   en_now, en_fall, en_rise;
    logic               pin_rise, pin_drop, pin_take, pd_event;
    depth_t             use_en, use_pin;
    depth_t [NPATH-1:0] tgt, lvl;
    logic [NPATH-1:0]   rdy;
    logic [NPATH-1:0]   dp_g, pll_g, ldo_g;

    assign en_now   = {rx_en, tx_en};
    assign en_fall  = st_q.prev_en & ~en_now;
    assign en_rise  = ~st_q.prev_en & en_now;
    assign pin_rise = pd_pin & ~st_q.prev_pin;
    assign pin_drop = ~pd_pin & st_q.prev_pin;
    assign pin_take = pin_rise & ~(|en_now);
    assign pd_event = (|en_fall) | pin_take;

    pcs_cfg u_cfg (
        .clk        (clk),
        .rst_n      (rst_n),
        .we_i       (cfg_we),
        .en_code_i  (cfg_en_mode),
        .pin_code_i (cfg_pin_mode),
        .pd_event_i (pd_event),
        .use_en_o   (use_en),
        .use_pin_o  (use_pin),
        .err_o      (cfg_err)
    );

    always_comb begin
        st_d          = st_q;
        st_d.prev_en  = en_now;
        st_d.prev_pin = pd_pin;
        for (int i = 0; i < NPATH; i++) begin
            if (en_fall[i])      st_d.en_lvl[i] = use_en;
            else if (en_rise[i]) st_d.en_lvl[i] = DEPTH_NONE;
        end
        if (pin_take)      st_d.pin_lvl = use_pin;
        else if (pin_drop) st_d.pin_lvl = DEPTH_NONE;
        st_d.pin_err = st_q.pin_err | (pin_rise & ~pin_take);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    for (genvar p = 0; p < NPATH; p++) begin : g_path
        assign tgt[p] = max_depth(st_q.en_lvl[p], st_q.pin_lvl);

        pcs_path #(
            .REC1_CYC (REC1_CYC),
            .REC2_CYC (REC2_CYC)
        ) u_path (
            .clk   (clk),
            .rst_n (rst_n),
            .tgt_i (tgt[p]),
            .lvl_o (lvl[p]),
            .rdy_o (rdy[p])
        );

        assign dp_g[p] = (lvl[p] >= DEPTH_PLL);

        if (SHARED_RES) begin : g_shared
            assign pll_g[p] = (lvl[0] >= DEPTH_PLL) && (lvl[1] >= DEPTH_PLL);
            assign ldo_g[p] = (lvl[0] == DEPTH_LDO) && (lvl[1] == DEPTH_LDO);
        end else begin : g_split
            assign pll_g[p] = (lvl[p] >= DEPTH_PLL);
            assign ldo_g[p] = (lvl[p] == DEPTH_LDO);
        end
    end

    assign tx_dp_pd  = dp_g[0];
    assign tx_pll_pd = pll_g[0];
    assign tx_ldo_pd = ldo_g[0];
    assign rx_dp_pd  = dp_g[1];
    assign rx_pll_pd = pll_g[1];
    assign rx_ldo_pd = ldo_g[1];
    assign tx_rdy    = rdy[0];
    assign rx_rdy    = rdy[1];
    assign pin_err   = st_q.pin_err;
endmodule

// File: rtl/chan_pwr_ctrl_chk.sv
module chan_pwr_ctrl_chk #(
    parameter bit SHARED_RES = 1'b1
) (
    input logic clk,
    input logic rst_n,
    input logic tx_en,
    input logic rx_en,
    input logic pd_pin,
    input logic tx_dp_pd,
    input logic tx_pll_pd,
    input logic tx_ldo_pd,
    input logic rx_dp_pd,
    input logic rx_pll_pd,
    input logic rx_ldo_pd,
    input logic tx_rdy,
    input logic rx_rdy,
    input logic pin_err,
    input logic cfg_err
);
    // R3: LDO gate only appears after the PLL gate was already on
    p_ldo_after_pll_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_ldo_pd) |-> $past(tx_pll_pd));

    p_ldo_needs_pll_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rx_ldo_pd |-> (rx_pll_pd && rx_dp_pd));

    // R6: illegal shared-pin raise flags an error on the next clock
    p_pin_err_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(pd_pin) && (tx_en || rx_en)) |=> pin_err);

    p_pin_err_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        pin_err |=> pin_err);

    // R7: config error is sticky
    p_cfg_err_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |=> cfg_err);

    // R9: ready is low while gated and on the clock a gate releases
    p_rdy_low_gated_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_dp_pd |-> !tx_rdy) and (rx_dp_pd |-> !rx_rdy));

    p_rdy_low_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(tx_dp_pd) |-> !tx_rdy);

    // R11: common resources show one state to both paths
    p_shared_same_r11: assert property (@(posedge clk) disable iff (!rst_n)
        SHARED_RES |-> ((tx_pll_pd == rx_pll_pd) && (tx_ldo_pd == rx_ldo_pd)));
endmodule

bind chan_pwr_ctrl chan_pwr_ctrl_chk #(.SHARED_RES(SHARED_RES)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tx_en     (tx_en),
    .rx_en     (rx_en),
    .pd_pin    (pd_pin),
    .tx_dp_pd  (tx_dp_pd),
    .tx_pll_pd (tx_pll_pd),
    .tx_ldo_pd (tx_ldo_pd),
    .rx_dp_pd  (rx_dp_pd),
    .rx_pll_pd (rx_pll_pd),
    .rx_ldo_pd (rx_ldo_pd),
    .tx_rdy    (tx_rdy),
    .rx_rdy    (rx_rdy),
    .pin_err   (pin_err),
    .cfg_err   (cfg_err)
);

// File: tb/chan_pwr_ctrl_tb.sv
module chan_pwr_ctrl_tb;
    localparam int REC1 = 6;
    localparam int REC2 = 14;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tx_en = 1'b0, rx_en = 1'b0, pd_pin = 1'b0, cfg_we = 1'b0;
    logic [1:0] cfg_en_mode = 2'd0, cfg_pin_mode = 2'd0;
    logic tx_dp_pd, tx_pll_pd, tx_ldo_pd, rx_dp_pd, rx_pll_pd, rx_ldo_pd;
    logic tx_rdy, rx_rdy, pin_err, cfg_err;

    int n_tests = 0;
    int n_fail  = 0;
    string cur_req = "R1";
    bit running = 1'b0;

    always #2 clk = ~clk;

    chan_pwr_ctrl #(.REC1_CYC(REC1), .REC2_CYC(REC2), .SHARED_RES(1'b1)) u_dut (
        .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .rx_en(rx_en), .pd_pin(pd_pin),
        .cfg_we(cfg_we), .cfg_en_mode(cfg_en_mode), .cfg_pin_mode(cfg_pin_mode),
        .tx_dp_pd(tx_dp_pd), .tx_pll_pd(tx_pll_pd), .tx_ldo_pd(tx_ldo_pd),
        .rx_dp_pd(rx_dp_pd), .rx_pll_pd(rx_pll_pd), .rx_ldo_pd(rx_ldo_pd),
        .tx_rdy(tx_rdy), .rx_rdy(rx_rdy), .pin_err(pin_err), .cfg_err(cfg_err)
    );

    // behavioural reference model, advanced on every rising clock
    int m_prev_en[2], m_prev_pin;
    int m_act_en, m_act_pin, m_stg_en, m_stg_pin, m_stg_vld;
    int m_en_req[2], m_pin_req, m_lvl[2], m_cnt[2];
    int m_perr, m_cerr;

    function automatic int imax(int a, int b);
        return (a > b) ? a : b;
    endfunction

    function automatic int clamp2(int v);
        return (v > 2) ? 2 : v;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_prev_en = '{0, 0}; m_prev_pin = 0;
            m_act_en = 0; m_act_pin = 0; m_stg_en = 0; m_stg_pin = 0; m_stg_vld = 0;
            m_en_req = '{0, 0}; m_pin_req = 0; m_lvl = '{0, 0}; m_cnt = '{0, 0};
            m_perr = 0; m_cerr = 0;
        end else begin
            int pins[2];
            int want, apply_en, apply_pin, raise_ok, event_pd;
            pins[0] = int'(tx_en); pins[1] = int'(rx_en);
            for (int p = 0; p < 2; p++) begin
                want = imax(m_en_req[p], m_pin_req);
                if (want > m_lvl[p]) begin
                    m_lvl[p] = m_lvl[p] + 1; m_cnt[p] = 0;
                end else if (want < m_lvl[p]) begin
                    m_cnt[p] = (m_lvl[p] == 2) ? REC2 : REC1; m_lvl[p] = want;
                end else if (m_cnt[p] > 0) begin
                    m_cnt[p] = m_cnt[p] - 1;
                end
            end
            apply_en  = m_stg_vld ? m_stg_en  : m_act_en;
            apply_pin = m_stg_vld ? m_stg_pin : m_act_pin;
            raise_ok  = (pd_pin && !m_prev_pin && !tx_en && !rx_en) ? 1 : 0;
            event_pd  = raise_ok;
            if (pd_pin && !m_prev_pin && !raise_ok) m_perr = 1;
            for (int p = 0; p < 2; p++) begin
                if (m_prev_en[p] == 1 && pins[p] == 0) begin
                    m_en_req[p] = apply_en; event_pd = 1;
                end else if (m_prev_en[p] == 0 && pins[p] == 1) begin
                    m_en_req[p] = 0;
                end
            end
            if (raise_ok) m_pin_req = apply_pin;
            else if (!pd_pin && m_prev_pin) m_pin_req = 0;
            if (event_pd) begin
                m_act_en = apply_en; m_act_pin = apply_pin; m_stg_vld = 0;
            end
            if (cfg_we) begin
                m_stg_en = clamp2(int'(cfg_en_mode));
                m_stg_pin = clamp2(int'(cfg_pin_mode));
                m_stg_vld = 1;
                if (cfg_en_mode == 3 || cfg_pin_mode == 3 ||
                    (cfg_pin_mode != 0 && clamp2(int'(cfg_pin_mode)) <= clamp2(int'(cfg_en_mode))))
                    m_cerr = 1;
            end
            m_prev_en = pins; m_prev_pin = int'(pd_pin);
        end
    end

    function automatic logic [9:0] model_vec();
        logic [9:0] v;
        v[9] = m_lvl[0] >= 1;
        v[8] = (m_lvl[0] >= 1) && (m_lvl[1] >= 1);
        v[7] = (m_lvl[0] == 2) && (m_lvl[1] == 2);
        v[6] = m_lvl[1] >= 1;
        v[5] = v[8];
        v[4] = v[7];
        v[3] = (m_lvl[0] == 0) && (imax(m_en_req[0], m_pin_req) == 0) && (m_cnt[0] == 0);
        v[2] = (m_lvl[1] == 0) && (imax(m_en_req[1], m_pin_req) == 0) && (m_cnt[1] == 0);
        v[1] = m_perr != 0;
        v[0] = m_cerr != 0;
        return v;
    endfunction

    // cycle-by-cycle comparison against the model
    always @(negedge clk) begin
        if (running && rst_n) begin
            logic [9:0] act;
            act = {tx_dp_pd, tx_pll_pd, tx_ldo_pd, rx_dp_pd, rx_pll_pd, rx_ldo_pd,
                   tx_rdy, rx_rdy, pin_err, cfg_err};
            n_tests++;
            if (act !== model_vec()) begin
                n_fail++;
                $display("FAIL %s cycle compare: actual %b expected %b", cur_req, act, model_vec());
            end
        end
    end

    task automatic chk(input string req, input logic act, input logic exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic write_modes(input logic [1:0] em, input logic [1:0] pm);
        cfg_we = 1'b1; cfg_en_mode = em; cfg_pin_mode = pm;
        tick(1);
        cfg_we = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        tick(3);
        rst_n = 1'b1;
        running = 1'b1;
        tick(1);
        // R1: state after reset
        chk("R1", tx_rdy, 1'b1);
        chk("R1", rx_rdy, 1'b1);
        chk("R1", tx_dp_pd | rx_ldo_pd | pin_err | cfg_err, 1'b0);

        // R4: mode 0 enable edges gate nothing
        cur_req = "R4";
        tx_en = 1'b1; rx_en = 1'b1; tick(3);
        tx_en = 1'b0; tick(5);
        chk("R4", tx_dp_pd, 1'b0);
        chk("R4", tx_rdy, 1'b1);
        tx_en = 1'b1; tick(2);

        // R8: staged write has no effect without an event
        cur_req = "R8";
        write_modes(2'd1, 2'd2);
        tick(5);
        chk("R8", tx_dp_pd | rx_dp_pd, 1'b0);
        chk("R7", cfg_err, 1'b0);

        // R2 and R11: one path down at mode 1
        cur_req = "R2";
        rx_en = 1'b0; tick(4);
        chk("R2", rx_dp_pd, 1'b1);
        chk("R2", rx_ldo_pd, 1'b0);
        chk("R2", tx_dp_pd, 1'b0);
        chk("R11", rx_pll_pd, 1'b0);
        chk("R9", rx_rdy, 1'b0);
        cur_req = "R11";
        tx_en = 1'b0; tick(4);
        chk("R11", tx_pll_pd, 1'b1);
        chk("R11", rx_pll_pd, 1'b1);

        // R9: recovery from depth 1 takes REC1 clocks
        cur_req = "R9";
        rx_en = 1'b1;
        tick(REC1 + 1);
        chk("R9", rx_rdy, 1'b0);
        chk("R11", rx_pll_pd, 1'b0);
        tick(1);
        chk("R9", rx_rdy, 1'b1);
        tx_en = 1'b1; tick(20);

        // R5 and R3: shared pin deepens both paths
        cur_req = "R5";
        tx_en = 1'b0; rx_en = 1'b0; tick(5);
        pd_pin = 1'b1; tick(1);
        chk("R3", tx_ldo_pd, 1'b0);
        chk("R3", tx_pll_pd, 1'b1);
        tick(1);
        chk("R5", tx_ldo_pd, 1'b1);
        chk("R5", rx_ldo_pd, 1'b1);
        tick(3);
        pd_pin = 1'b0; tick(3);
        chk("R5", tx_ldo_pd, 1'b0);
        chk("R5", tx_dp_pd, 1'b1);
        chk("R9", tx_rdy, 1'b0);
        tx_en = 1'b1; rx_en = 1'b1; tick(25);
        chk("R9", tx_rdy & rx_rdy, 1'b1);

        // R6: illegal shared-pin raise
        cur_req = "R6";
        pd_pin = 1'b1; tick(4);
        chk("R6", pin_err, 1'b1);
        chk("R6", tx_dp_pd | rx_dp_pd, 1'b0);
        pd_pin = 1'b0; tick(3);
        chk("R6", pin_err, 1'b1);

        // R7: illegal mode pairs
        cur_req = "R7";
        write_modes(2'd2, 2'd1);
        tick(2);
        chk("R7", cfg_err, 1'b1);
        write_modes(2'd3, 2'd0);
        tick(2);
        chk("R7", cfg_err, 1'b1);

        // R1: reset mid-run clears flags
        cur_req = "R1";
        rst_n = 1'b0; tick(2);
        rst_n = 1'b1; tick(2);
        chk("R1", pin_err, 1'b0);
        chk("R1", cfg_err, 1'b0);

        // R10: enable bounce during a depth-2 power-down
        cur_req = "R10";
        write_modes(2'd2, 2'd0);
        tick(2);
        tx_en = 1'b0; tick(1);
        tx_en = 1'b1; tick(1);
        chk("R10", tx_dp_pd, 1'b1);
        tick(1);
        chk("R10", tx_dp_pd, 1'b0);
        chk("R10", tx_rdy, 1'b0);
        tick(REC1 - 1);
        chk("R10", tx_rdy, 1'b0);
        tick(1);
        chk("R10", tx_rdy, 1'b1);
        tick(3);

        // R8: write coinciding with an event stays staged
        cur_req = "R8";
        rx_en = 1'b0; tick(3);
        tx_en = 1'b0; cfg_we = 1'b1; cfg_en_mode = 2'd1; cfg_pin_mode = 2'd0;
        tick(1);
        cfg_we = 1'b0;
        tick(4);
        chk("R8", tx_ldo_pd, 1'b1);
        tx_en = 1'b1; rx_en = 1'b1; tick(25);
        tx_en = 1'b0; rx_en = 1'b0; tick(5);
        chk("R8", tx_ldo_pd, 1'b0);
        chk("R8", tx_pll_pd, 1'b1);
        tx_en = 1'b1; rx_en = 1'b1; tick(25);
        chk("R9", tx_rdy & rx_rdy, 1'b1);

        running = 1'b0;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule